// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Timer with Dead Time

This block produces the gate drive for a three-phase inverter bridge. A single counter sweeps up from zero to the period value and back down to zero. Each phase compares the counter against its own compare value to form a reference, and the reference is split into a high-side and a low-side gate with a programmable dead band between them. A fourth compare value shapes a trigger that starts the phase-current conversion at a chosen point in the cycle.

A repetition counter thins the counter's turn-arounds into an update pulse that paces the control loop. The period and all four compare values are taken from the inputs only when that pulse fires, or at any time while the block is disabled. Software can therefore change them at any moment without producing a half-applied cycle. The dead-time input is applied as it stands.

Top module: `cpwm_timer`

## Requirements
- R1: While `en_i` is low, all six gates and `upd_o` are low, and `adc_trig_o` is low from the following cycle onward. The counter rests at zero counting up, with the repetition count reloaded.
- R2: With active period A, the counter visits 0,1,…,A and then A,A−1,…,0, and each end value is held for two cycles. One PWM cycle is therefore 2·(A+1) clocks, and the first cycle starts on the first enabled clock.
- R3: A turn-around is the last cycle at the top or at the bottom of the sweep. `upd_o` is a one-cycle pulse on every (REP_CNT+1)-th turn-around. With the default REP_CNT = 1 it occurs in the final bottom cycle of each PWM cycle, so the first pulse comes 2·(A+1)−1 cycles after enable and the pulses are then 2·(A+1) cycles apart.
- R4: `period_i` and `cmp_i` are copied to the active settings at the clock edge that ends an `upd_o` cycle, or at every edge while disabled. Between those edges, changes on these inputs have no effect on any output.
- R5: The phase i reference is high while counter < active compare i, in both directions. A compare of 0 keeps it low, and a compare above A keeps it high.
- R6: The high gate of a phase rises DT+1 cycles after its reference goes high and falls one cycle after the reference goes low. The low gate mirrors this on the inverted reference. The two gates of a phase are never high together, and with DT > 0 neither gate rises in the cycle right after the other gate was high.
- R7: A reference run of L cycles yields a gate pulse of L−DT cycles when L > DT. Otherwise it yields no pulse at all.
- R8: `adc_trig_o` is registered. In each cycle it shows whether, in the previous cycle, the block was enabled and the counter was below active compare 3 (field index 3 of `cmp_i`).
- R9: With DT = 0, the low gate is the exact complement of the high gate while the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock, divide-by-one |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low holds the counter and forces the gates off |
| period_i | input | CNT_W | Period value A, preloaded |
| dead_i | input | DT_W | Dead-time length DT in clocks, used directly |
| cmp_i | input | (N_PH+1)·CNT_W | Compare values, index 0..N_PH−1 for phases, index N_PH for the trigger, preloaded |
| gate_hi_o | output | N_PH | High-side gate per phase |
| gate_lo_o | output | N_PH | Low-side gate per phase |
| adc_trig_o | output | 1 | Current-sampling trigger |
| upd_o | output | 1 | Update pulse for loop scheduling |

## Verification
The dead-band assertions assume that `dead_i` stays steady while the block runs. A change in the middle of a dead band could legally shorten the gap, so the stimulus changes `dead_i` only while `en_i` is low. The shadow-hold and range properties assume that a new period is applied only through the update pulse. For that reason the stimulus writes new periods and compares at arbitrary cycles but never relies on a mid-cycle take-over. The stimulus covers compares of zero, compares beyond the period, and pulses shorter than the dead time, so that the steady-high, steady-low and suppressed-pulse cases are all reached.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // Sweep direction of the shared counter.
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  // Width of a down-counter that must hold the value n.
  function automatic int rep_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cpwm_updown.sv
module cpwm_updown
  import cpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int REP_CNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);

  localparam int REP_W = rep_width(REP_CNT);
  localparam logic [REP_W-1:0] REP_INIT = REP_W'(REP_CNT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             at_top, at_bot, turn, ce;

  // next state
  always_comb begin
    at_top = (dir_q == CNT_UP) && (cnt_q >= arr_i);
    at_bot = (dir_q == CNT_DOWN) && (cnt_q == '0);
    turn   = at_top || at_bot;
    upd_o  = en_i && turn && (rep_q == '0);
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    rep_d  = rep_q;
    if (!en_i) begin
      cnt_d = '0;
      dir_d = CNT_UP;
      rep_d = REP_INIT;
    end else begin
      if (at_top) begin
        dir_d = CNT_DOWN;
      end else if (at_bot) begin
        dir_d = CNT_UP;
      end else if (dir_q == CNT_UP) begin
        cnt_d = cnt_q + CNT_W'(1);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
      if (turn) begin
        rep_d = (rep_q == '0) ? REP_INIT : rep_q - REP_W'(1);
      end
    end
    // idle and already parked: no clocking needed
    ce = en_i || (cnt_q != '0) || (dir_q != CNT_UP) || (rep_q != REP_INIT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
      rep_q <= REP_INIT;
    end else if (ce) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      rep_q <= rep_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cpwm_shadow.sv
module cpwm_shadow #(
  parameter int CNT_W = 16,
  parameter int NCH   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_i,
  input  logic [CNT_W-1:0]          arr_i,
  input  logic [NCH-1:0][CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0]          arr_o,
  output logic [NCH-1:0][CNT_W-1:0] cmp_o
);

  logic [CNT_W-1:0] arr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q <= '0;
    end else if (ld_i) begin
      arr_q <= arr_i;
    end
  end

  assign arr_o = arr_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cmp
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '0;
      end else if (ld_i) begin
        cmp_q <= cmp_i[ch];
      end
    end
    assign cmp_o[ch] = cmp_q;
  end

endmodule

// File: rtl/cpwm_deadband.sv
module cpwm_deadband #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            ref_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            hi_o,
  output logic            lo_o
);

  logic            lvl_q, lvl_d;
  logic [DT_W-1:0] run_q, run_d;
  logic            ce, settled;

  // next state: run_q counts cycles since the reference last changed
  always_comb begin
    lvl_d = lvl_q;
    run_d = run_q;
    if (!en_i) begin
      lvl_d = 1'b0;
      run_d = '0;
    end else if (ref_i != lvl_q) begin
      lvl_d = ref_i;
      run_d = '0;
    end else if (run_q != '1) begin
      run_d = run_q + DT_W'(1);
    end
    ce      = (lvl_d != lvl_q) || (run_d != run_q);
    settled = (run_q >= dt_i);
    hi_o    = en_i && lvl_q && settled;
    lo_o    = en_i && !lvl_q && settled;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (ce) begin
      lvl_q <= lvl_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer
  import cpwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DT_W    = 8,
  parameter int N_PH    = 3,
  parameter int REP_CNT = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         period_i,
  input  logic [DT_W-1:0]          dead_i,
  input  logic [N_PH:0][CNT_W-1:0] cmp_i,
  output logic [N_PH-1:0]          gate_hi_o,
  output logic [N_PH-1:0]          gate_lo_o,
  output logic                     adc_trig_o,
  output logic                     upd_o
);

  localparam int NCH  = N_PH + 1;
  localparam int TRIG = N_PH;

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [CNT_W-1:0]          cnt;
  logic [CNT_W-1:0]          arr_act;
  logic [NCH-1:0][CNT_W-1:0] cmp_act;
  logic [NCH-1:0]            ref_lvl;
  logic                      upd;
  logic                      shadow_ld;

  cpwm_updown #(
    .CNT_W  (CNT_W),
    .REP_CNT(REP_CNT)
  ) i_updown (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .en_i (en_i),
    .arr_i(arr_act),
    .cnt_o(cnt),
    .upd_o(upd)
  );

  assign shadow_ld = !en_i || upd;

  cpwm_shadow #(
    .CNT_W(CNT_W),
    .NCH  (NCH)
  ) i_shadow (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .ld_i (shadow_ld),
    .arr_i(period_i),
    .cmp_i(cmp_i),
    .arr_o(arr_act),
    .cmp_o(cmp_act)
  );

  // compare references, high while counter is below the compare value
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ref
    assign ref_lvl[ch] = (cnt < cmp_act[ch]);
  end

  for (genvar ph = 0; ph < N_PH; ph++) begin : g_phase
    cpwm_deadband #(
      .DT_W(DT_W)
    ) i_deadband (
      .clk  (clk),
      .rst_n(rst_sync_q),
      .en_i (en_i),
      .ref_i(ref_lvl[ph]),
      .dt_i (dead_i),
      .hi_o (gate_hi_o[ph]),
      .lo_o (gate_lo_o[ph])
    );
  end

  // trigger register
  logic trig_q, trig_d;
  always_comb begin
    trig_d = en_i && ref_lvl[TRIG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
    end else if (!rst_sync_q) begin
      trig_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
    end
  end

  assign adc_trig_o = trig_q;
  assign upd_o      = upd;

endmodule

// File: rtl/cpwm_timer_chk.sv
module cpwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 8,
  parameter int N_PH  = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     en_i,
  input logic [DT_W-1:0]          dead_i,
  input logic [N_PH-1:0]          gate_hi_o,
  input logic [N_PH-1:0]          gate_lo_o,
  input logic                     adc_trig_o,
  input logic                     upd_o,
  input logic [CNT_W-1:0]         cnt,
  input logic [CNT_W-1:0]         arr_act,
  input logic [N_PH:0][CNT_W-1:0] cmp_act
);

  for (genvar ph = 0; ph < N_PH; ph++) begin : g_ph
    // R6
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_o[ph] && gate_lo_o[ph]));
    // R6
    gap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dead_i != '0) && $rose(gate_hi_o[ph])) |-> !$past(gate_lo_o[ph]));
    // R6
    gap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dead_i != '0) && $rose(gate_lo_o[ph])) |-> !$past(gate_hi_o[ph]));
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (gate_hi_o == '0) && (gate_lo_o == '0) && !upd_o);
  // R1
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt == '0) && !adc_trig_o);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= arr_act);
  // R3
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);
  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !upd_o) |=> $stable(cmp_act) && $stable(arr_act));
  // R8
  trig_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_trig_o) |-> $past(en_i));

endmodule

bind cpwm_timer cpwm_timer_chk #(
  .CNT_W(CNT_W),
  .DT_W (DT_W),
  .N_PH (N_PH)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_q),
  .en_i      (en_i),
  .dead_i    (dead_i),
  .gate_hi_o (gate_hi_o),
  .gate_lo_o (gate_lo_o),
  .adc_trig_o(adc_trig_o),
  .upd_o     (upd_o),
  .cnt       (cnt),
  .arr_act   (arr_act),
  .cmp_act   (cmp_act)
);

// File: tb/test_cpwm_timer.sv
module test_cpwm_timer;

  localparam int CNT_W = 16;
  localparam int DT_W  = 8;
  localparam int N_PH  = 3;
  localparam int REP   = 1;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     en;
  logic [CNT_W-1:0]         period;
  logic [DT_W-1:0]          dead;
  logic [N_PH:0][CNT_W-1:0] cmp;
  logic [N_PH-1:0]          hi, lo;
  logic                     trig, upd;

  always #5 clk = ~clk;

  cpwm_timer #(
    .CNT_W(CNT_W), .DT_W(DT_W), .N_PH(N_PH), .REP_CNT(REP)
  ) i_cpwm_timer (
    .clk(clk), .rst_n(rst_n), .en_i(en), .period_i(period), .dead_i(dead),
    .cmp_i(cmp), .gate_hi_o(hi), .gate_lo_o(lo), .adc_trig_o(trig), .upd_o(upd)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [N_PH-1:0] hi;
    logic [N_PH-1:0] lo;
    logic            trig;
    logic            upd;
  } exp_t;

  exp_t exp_q[$];

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  // Reference model state, built from the requirements
  bit mdl_on = 1'b0;
  int m_cnt, m_arr, m_rep, m_trig;
  bit m_up;
  int m_cmp[N_PH+1];
  int m_lvl[N_PH];
  int m_run[N_PH];

  // Driver side of the scoreboard: predicts each cycle and pushes it
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (mdl_on) begin
        exp_t e;
        bit turn, up_n;
        int cnt_n, dt;
        dt = int'(dead);
        turn = m_up ? (m_cnt >= m_arr) : (m_cnt == 0);
        for (int i = 0; i < N_PH; i++) begin
          e.hi[i] = en && (m_lvl[i] != 0) && (m_run[i] >= dt);
          e.lo[i] = en && (m_lvl[i] == 0) && (m_run[i] >= dt);
        end
        e.trig = m_trig[0];
        e.upd  = en && turn && (m_rep == 0);
        exp_q.push_back(e);
        // advance to the next cycle
        for (int i = 0; i < N_PH; i++) begin
          int r;
          r = (m_cnt < m_cmp[i]) ? 1 : 0;
          if (!en) begin m_lvl[i] = 0; m_run[i] = 0; end
          else if (r != m_lvl[i]) begin m_lvl[i] = r; m_run[i] = 0; end
          else if (m_run[i] < 255) m_run[i]++;
        end
        m_trig = (en && (m_cnt < m_cmp[N_PH])) ? 1 : 0;
        cnt_n = m_cnt; up_n = m_up;
        if (!en) begin
          cnt_n = 0; up_n = 1'b1; m_rep = REP;
        end else begin
          if (turn) begin
            up_n = !m_up;
            m_rep = (m_rep == 0) ? REP : m_rep - 1;
          end else cnt_n = m_up ? m_cnt + 1 : m_cnt - 1;
        end
        if (!en || e.upd) begin
          m_arr = int'(period);
          for (int i = 0; i <= N_PH; i++) m_cmp[i] = int'(cmp[i]);
        end
        m_cnt = cnt_n; m_up = up_n;
      end
    end
  end

  // Monitor side: pops one prediction per cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check("R5/R6/R7/R9 gates", int'({hi, lo}), int'({e.hi, e.lo}));
        check("R8 trigger", int'(trig), int'(e.trig));
        check("R3 update", int'(upd), int'(e.upd));
      end
    end
  end

  task automatic set_cfg(input int a, input int d, input int c0, input int c1,
                         input int c2, input int c3);
    @(negedge clk);
    period = CNT_W'(a);
    dead   = DT_W'(d);
    cmp[0] = CNT_W'(c0);
    cmp[1] = CNT_W'(c1);
    cmp[2] = CNT_W'(c2);
    cmp[3] = CNT_W'(c3);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input bit v);
    @(negedge clk);
    en = v;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; period = '0; dead = '0; cmp = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run(3);
    m_cnt = 0; m_up = 1'b1; m_rep = REP; m_arr = 0; m_trig = 0;
    for (int i = 0; i <= N_PH; i++) m_cmp[i] = 0;
    for (int i = 0; i < N_PH; i++) begin m_lvl[i] = 0; m_run[i] = 0; end
    mdl_on = 1'b1;
    #4;
    // R1: quiet outputs after reset
    check("R1 reset gates", int'({hi, lo}), 0);
    check("R1 reset trig/upd", int'({trig, upd}), 0);

    // R5 R7: normal, runt (cmp 1 -> 2-cycle run < DT 3), always-high (cmp > A)
    set_cfg(19, 3, 10, 1, 20, 4);
    set_en(1'b1);
    run(170);
    // R4: compares change mid-cycle, taken only at the next update; cmp 0 -> always low (R5)
    set_cfg(19, 3, 5, 12, 0, 15);
    run(120);
    // R1: disable mid-run
    set_en(1'b0);
    run(3);
    #4;
    check("R1 disabled gates", int'({hi, lo}), 0);
    check("R1 disabled trig/upd", int'({trig, upd}), 0);
    // R9: zero dead time, short period
    set_cfg(7, 0, 3, 4, 8, 2);
    set_en(1'b1);
    run(80);
    // R4: period change while running
    set_cfg(11, 0, 6, 1, 9, 11);
    run(100);
    set_en(1'b0);
    run(3);

    // R2 R3 R7 at full scale: A=3999, DT=128, phase 1 run 120 < 128
    set_cfg(3999, 128, 2000, 60, 3000, 3990);
    begin
      int k, gap, rises_ph0, rises_ph1;
      bit prev0, prev1;
      @(negedge clk);
      en = 1'b1;
      k = 0;
      #4;
      while (!upd && k < 20000) begin
        @(negedge clk); #4; k++;
      end
      check("R3 first update delay", k, 2 * (3999 + 1) - 1);
      gap = 0; rises_ph0 = 0; rises_ph1 = 0;
      prev0 = hi[0]; prev1 = hi[1];
      do begin
        @(negedge clk); #4; gap++;
        if (hi[0] && !prev0) rises_ph0++;
        if (hi[1] && !prev1) rises_ph1++;
        prev0 = hi[0]; prev1 = hi[1];
      end while (!upd && gap < 20000);
      check("R2 cycle length", gap, 2 * (3999 + 1));
      check("R6 one high pulse per cycle", rises_ph0, 1);
      check("R7 runt suppressed", rises_ph1, 0);
    end
    run(50);
    set_en(1'b0);
    run(5);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule